// File: doc/BRIEF.md
# Single-Step and Branch Trace Unit

This unit sits at the completion stage of a processor pipeline and watches each instruction as it retires. When the machine state word has single-step tracing or branch tracing turned on, a qualifying completion raises a trace interrupt request. The request comes with the two values that interrupt entry saves:

- the address of the instruction that follows the one that completed;
- a status word built from the machine state word.

The request registers one cycle after the completion strobe. It then stays up, with its saved values frozen, until the interrupt logic acknowledges it. A return-from-interrupt instruction never single-steps. An instruction that raised some other interrupt never produces a trace. A branch that qualifies under both modes produces one request, not two.

Bit numbering in this note is little-endian: bit 0 is the LSB of a 32-bit word. The single-step enable is state bit 10 and the branch-trace enable is state bit 9.

Top module: `step_trace_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `trace_req` is 0 and both `save_pc` and `save_status` are 0.
- R2: A completion (`retire_vld`=1) with `state_word[10]`=1, `retire_is_rfi`=0 and `retire_faulted`=0 makes `trace_req` 1 on the cycle after the completion edge.
- R3: With only single-step enabled, a completion that has `retire_is_rfi`=1 and `retire_is_branch`=0 raises no trace.
- R4: A completion with `state_word[9]`=1, `retire_is_branch`=1 and `retire_faulted`=0 raises a trace, whatever the single-step bit is.
- R5: A completion with `retire_faulted`=1 raises no trace under any enable setting.
- R6: When a trace is raised, `save_pc` equals the `retire_next_pc` presented with the triggering completion.
- R7: When a trace is raised, `save_status[15:0]` equals `state_word[15:0]` sampled with the triggering completion, and `save_status[31:16]` is 0.
- R8: While `trace_req`=1 and `trace_ack`=0, the request stays 1. In that state `save_pc` and `save_status` keep their values, and further completions do not change them.
- R9: A branch completing with both enables set produces exactly one request cycle when `trace_ack` is held at 1.
- R10: With `state_word[10]`=0 and `state_word[9]`=0, no completion raises a trace.
- R11: In a cycle where `trace_req`=1 and `trace_ack`=1, a qualifying completion loads a new request with fresh saved values. Without such a completion, `trace_req` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | An instruction completes this cycle |
| retire_is_rfi | input | 1 | Completing instruction is a return from interrupt |
| retire_is_branch | input | 1 | Completing instruction is a branch |
| retire_faulted | input | 1 | Completing instruction raised another interrupt |
| retire_next_pc | input | 32 | Address of the instruction after the completing one |
| state_word | input | 32 | Machine state word; bit 10 single-step, bit 9 branch-trace |
| trace_ack | input | 1 | Interrupt logic has taken the pending trace |
| trace_req | output | 1 | Trace interrupt pending |
| save_pc | output | 32 | Value for the first save/restore register |
| save_status | output | 32 | Value for the second save/restore register |

## Verification
The hardest state to reach is a pending request that is still unacknowledged when further qualifying completions arrive. The same applies to the edge where an acknowledge and a new completion fall in one cycle. The stimulus holds `trace_ack` low across several completions that carry different addresses and state words, and checks that the first saved pair survives. It then raises the acknowledge in the same cycle as a new completion and checks that the new pair is loaded.

// File: rtl/step_trace_pkg.sv
package step_trace_pkg;
  localparam int XLEN       = 32;
  localparam int KEEP_W     = 16;
  localparam int STEP_BIT   = 10;
  localparam int BRANCH_BIT = 9;

  // Status word for interrupt entry: upper half cleared, lower half copied.
  function automatic logic [XLEN-1:0] pack_status(input logic [XLEN-1:0] sw);
    logic [XLEN-1:0] r;
    r = '0;
    r[KEEP_W-1:0] = sw[KEEP_W-1:0];
    return r;
  endfunction

  function automatic logic step_wants(input logic en, input logic is_rfi);
    return en && !is_rfi;
  endfunction

  function automatic logic branch_wants(input logic en, input logic is_br);
    return en && is_br;
  endfunction
endpackage

// File: rtl/trace_qualify.sv
module trace_qualify
  import step_trace_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int S_BIT  = STEP_BIT,
  parameter int B_BIT  = BRANCH_BIT
)(
  input  logic         vld,
  input  logic         is_rfi,
  input  logic         is_branch,
  input  logic         faulted,
  input  logic [W-1:0] sw,
  output logic         step_hit,
  output logic         branch_hit,
  output logic         hit
);
  logic step_en, branch_en, clean;

  assign step_en    = sw[S_BIT];
  assign branch_en  = sw[B_BIT];
  assign clean      = vld && !faulted;
  assign step_hit   = clean && step_wants(step_en, is_rfi);
  assign branch_hit = clean && branch_wants(branch_en, is_branch);
  // both causes fold into one request
  assign hit        = step_hit || branch_hit;
endmodule

// File: rtl/trace_pending.sv
module trace_pending
  import step_trace_pkg::*;
#(
  parameter int W = XLEN
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         ack,
  input  logic [W-1:0] next_pc,
  input  logic [W-1:0] status_in,
  output logic         hold,
  output logic         req,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] status_q
);
  logic load;

  assign hold = req && !ack;
  assign load = hit && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= 1'b0;
      pc_q     <= '0;
      status_q <= '0;
    end else begin
      req <= hold || hit;
      if (load) begin
        pc_q     <= next_pc;
        status_q <= status_in;
      end
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (req && $stable(pc_q) && $stable(status_q)));

  // R11
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !hit) |=> !req);
endmodule

// File: rtl/step_trace_unit.sv
module step_trace_unit
  import step_trace_pkg::*;
#(
  parameter int W = XLEN
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         retire_vld,
  input  logic         retire_is_rfi,
  input  logic         retire_is_branch,
  input  logic         retire_faulted,
  input  logic [W-1:0] retire_next_pc,
  input  logic [W-1:0] state_word,
  input  logic         trace_ack,
  output logic         trace_req,
  output logic [W-1:0] save_pc,
  output logic [W-1:0] save_status
);
  logic         step_hit, branch_hit, trace_hit, pend_hold;
  logic [W-1:0] status_next;

  assign status_next = pack_status(state_word);

  trace_qualify #(.W(W)) u_qual (
    .vld        (retire_vld),
    .is_rfi     (retire_is_rfi),
    .is_branch  (retire_is_branch),
    .faulted    (retire_faulted),
    .sw         (state_word),
    .step_hit   (step_hit),
    .branch_hit (branch_hit),
    .hit        (trace_hit)
  );

  trace_pending #(.W(W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (trace_hit),
    .ack       (trace_ack),
    .next_pc   (retire_next_pc),
    .status_in (status_next),
    .hold      (pend_hold),
    .req       (trace_req),
    .pc_q      (save_pc),
    .status_q  (save_status)
  );

  // R5
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && retire_faulted && !pend_hold) |=> !trace_req);

  // R3
  rfi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && retire_is_rfi && !retire_is_branch && !pend_hold) |=> !trace_req);

  // R6
  pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_hit && !pend_hold) |=> (save_pc == $past(retire_next_pc)));

  // R7
  status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> (save_status[W-1:KEEP_W] == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_hit |=> trace_req);

  // R4
  branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_hit |=> trace_req);
endmodule

// File: tb/step_trace_unit_test.sv
module step_trace_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_vld = 1'b0, retire_is_rfi = 1'b0, retire_is_branch = 1'b0, retire_faulted = 1'b0;
  logic [31:0] retire_next_pc = '0, state_word = '0;
  logic        trace_ack = 1'b0;
  logic        trace_req;
  logic [31:0] save_pc, save_status;

  int vectors = 0, errors = 0;
  localparam logic [31:0] SS = 32'h0000_0400;
  localparam logic [31:0] BT = 32'h0000_0200;

  always #4 clk = ~clk;

  step_trace_unit uut (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_is_rfi(retire_is_rfi),
    .retire_is_branch(retire_is_branch), .retire_faulted(retire_faulted),
    .retire_next_pc(retire_next_pc), .state_word(state_word), .trace_ack(trace_ack),
    .trace_req(trace_req), .save_pc(save_pc), .save_status(save_status)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one completion at a negedge, return at the next negedge
  task automatic retire(input logic [31:0] pc, input logic [31:0] sw,
                        input logic rfi, input logic br, input logic flt);
    retire_vld = 1'b1; retire_next_pc = pc; state_word = sw;
    retire_is_rfi = rfi; retire_is_branch = br; retire_faulted = flt;
    @(negedge clk);
    retire_vld = 1'b0; retire_is_rfi = 1'b0; retire_is_branch = 1'b0; retire_faulted = 1'b0;
  endtask

  task automatic clear_req();
    trace_ack = 1'b1;
    @(negedge clk);
    trace_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(trace_req == 1'b0, "R1 req", {31'b0, trace_req}, 32'h0);
    chk(save_pc == '0, "R1 save_pc", save_pc, 32'h0);
    chk(save_status == '0, "R1 save_status", save_status, 32'h0);
  endtask

  task automatic t_step();
    retire(32'h0000_1004, SS, 1'b0, 1'b0, 1'b0);
    chk(trace_req == 1'b1, "R2 req", {31'b0, trace_req}, 32'h1);
    chk(save_pc == 32'h0000_1004, "R6 save_pc", save_pc, 32'h0000_1004);
    clear_req();
  endtask

  task automatic t_rfi();
    retire(32'h0000_2000, SS, 1'b1, 1'b0, 1'b0);
    chk(trace_req == 1'b0, "R3 rfi no trace", {31'b0, trace_req}, 32'h0);
  endtask

  task automatic t_branch();
    retire(32'h0000_3000, BT, 1'b0, 1'b0, 1'b0);
    chk(trace_req == 1'b0, "R4 non-branch no trace", {31'b0, trace_req}, 32'h0);
    retire(32'h0000_3008, BT, 1'b0, 1'b1, 1'b0);
    chk(trace_req == 1'b1, "R4 branch trace", {31'b0, trace_req}, 32'h1);
    chk(save_pc == 32'h0000_3008, "R6 branch pc", save_pc, 32'h0000_3008);
    clear_req();
    retire(32'h0000_300C, BT, 1'b1, 1'b1, 1'b0);
    chk(trace_req == 1'b1, "R4 rfi branch traced", {31'b0, trace_req}, 32'h1);
    clear_req();
  endtask

  task automatic t_fault();
    retire(32'h0000_4000, SS | BT, 1'b0, 1'b1, 1'b1);
    chk(trace_req == 1'b0, "R5 faulted", {31'b0, trace_req}, 32'h0);
  endtask

  task automatic t_status();
    retire(32'h0000_5000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk(save_status == 32'h0000_FFFF, "R7 all ones", save_status, 32'h0000_FFFF);
    clear_req();
    retire(32'h0000_5004, 32'hA5A5_0400 | 32'h0000_0003, 1'b0, 1'b0, 1'b0);
    chk(save_status == 32'h0000_0403, "R7 pattern", save_status, 32'h0000_0403);
    clear_req();
  endtask

  task automatic t_hold();
    retire(32'h0000_6000, SS | 32'h0000_0011, 1'b0, 1'b0, 1'b0);
    retire(32'h0000_6100, SS | 32'h0000_0022, 1'b0, 1'b0, 1'b0);
    retire(32'h0000_6200, SS | BT, 1'b0, 1'b1, 1'b0);
    chk(trace_req == 1'b1, "R8 still pending", {31'b0, trace_req}, 32'h1);
    chk(save_pc == 32'h0000_6000, "R8 pc held", save_pc, 32'h0000_6000);
    chk(save_status == 32'h0000_0411, "R8 status held", save_status, 32'h0000_0411);
    trace_ack = 1'b1;
    @(negedge clk);
    trace_ack = 1'b0;
    chk(trace_req == 1'b0, "R11 drop on ack", {31'b0, trace_req}, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_both();
    int highs = 0;
    trace_ack = 1'b1;
    retire(32'h0000_7000, SS | BT, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      if (trace_req) highs++;
      @(negedge clk);
    end
    trace_ack = 1'b0;
    chk(highs == 1, "R9 single request", highs, 32'd1);
  endtask

  task automatic t_none();
    retire(32'h0000_8000, 32'hFFFF_F9FF, 1'b0, 1'b1, 1'b0);
    chk(trace_req == 1'b0, "R10 disabled", {31'b0, trace_req}, 32'h0);
  endtask

  task automatic t_reload();
    retire(32'h0000_9000, SS, 1'b0, 1'b0, 1'b0);
    trace_ack = 1'b1;
    retire(32'h0000_9100, SS | 32'h0000_0055, 1'b0, 1'b0, 1'b0);
    trace_ack = 1'b0;
    chk(trace_req == 1'b1, "R11 reload req", {31'b0, trace_req}, 32'h1);
    chk(save_pc == 32'h0000_9100, "R11 reload pc", save_pc, 32'h0000_9100);
    chk(save_status == 32'h0000_0455, "R11 reload status", save_status, 32'h0000_0455);
    clear_req();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step();
    t_rfi();
    t_branch();
    t_fault();
    t_status();
    t_hold();
    t_both();
    t_none();
    t_reload();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule